// File: doc/BRIEF.md
# Hot-Swap Bus Connection Sequencer

This block is the digital controller of a hot-swappable two-wire bus buffer. It decides when the card-side segment of an I2C/SMBus bus may be joined to the backplane segment. The block samples an active-high enable, a power-good flag from the undervoltage lockout, and the logic levels of the two data lines and two clock lines: the input (card) pair and the output (backplane) pair. It produces a connect command for the analog switches, a precharge enable that biases the lines while the card is inserted, a rise-time accelerator enable and an active-high ready status.

After power is good and enable is high, the block runs a fixed-length initialization phase that stands in for reference settling. It then arms its monitors and joins the two sides on whichever comes first. One trigger is an unbroken stretch of all four lines high that lasts the bus-idle time. The other is a STOP condition on the input pair while all four lines are high. Removing enable or power drops every output at once. A later re-enable repeats the whole sequence.

Top module: `hotswap_link_seq`

## Requirements
- R1: While `pwr_good_i` or `en_i` is low, `connect_o`, `precharge_o`, `accel_o` and `ready_o` are all 0. Reset also leaves all four at 0.
- R2: Once the synchronized enable and power-good are both high, an initialization phase of `INIT_CYCLES` clocks runs before any idle or STOP monitoring. A STOP seen during this phase does not cause a connection.
- R3: `precharge_o` is 1 from the start of initialization until the connection is made, and falls in the same cycle that `connect_o` rises. The two are never 1 together.
- R4: After initialization, if all four lines stay high for `IDLE_US` microseconds (`CLK_HZ/1000*IDLE_US/1000` clocks), `connect_o` goes to 1.
- R5: A low sample on any of the four lines while armed restarts the idle count from zero.
- R6: After initialization, a STOP (data-in rises while clock-in is high) with both output-side lines high connects within a few clocks, without waiting for the idle time.
- R7: A rising data-in edge while either output-side line is low does not connect.
- R8: `ready_o` is 1 only while connected with enable and power-good high. It is 0 during initialization and during qualification.
- R9: Driving `en_i` low forces all four outputs to 0 in the same cycle, with no clock edge needed.
- R10: Raising enable again after a disable repeats initialization and idle/STOP qualification. The block does not reconnect at once.
- R11: `accel_o` is 1 only while connected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Active-high enable (asynchronous) |
| pwr_good_i | input | 1 | Supply above lockout threshold (asynchronous) |
| sda_in_i | input | 1 | Card-side data line level |
| scl_in_i | input | 1 | Card-side clock line level |
| sda_out_i | input | 1 | Backplane-side data line level |
| scl_out_i | input | 1 | Backplane-side clock line level |
| connect_o | output | 1 | Join card and backplane segments |
| precharge_o | output | 1 | Enable line precharge bias |
| accel_o | output | 1 | Enable rise-time accelerators |
| ready_o | output | 1 | Start-up complete and connected |

## Verification
Several line patterns exercise the connection decision. With all lines quietly high, the connection must come from the idle timer, at its nominal time. A STOP on the input pair after initialization must connect far earlier than the timer would. The same STOP edge placed inside initialization shows that the monitors are gated until arming. A rising data edge while an output-side line is held low shows that the all-high qualification is applied. A short low glitch on one backplane line moves the timer-driven connection late, which confirms the restart. A disable followed by a re-enable checks that outputs drop at once and that the full sequence runs again.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_INIT   = 2'd1,
    ST_ARMED  = 2'd2,
    ST_LINKED = 2'd3
  } hsl_state_e;

  // Clocks in the bus-idle window: hz/1000 * us / 1000, at least one.
  function automatic int unsigned idle_cycles(input int unsigned hz,
                                              input int unsigned us);
    int unsigned c;
    c = ((hz / 1000) * us) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/hsl_sync.sv
module hsl_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[b];
        s2_q <= RST_VAL[b];
      end else begin
        s1_q <= d_i[b];
        s2_q <= s1_q;
      end
    end
    assign q_o[b] = s2_q;
  end
endmodule

// File: rtl/hsl_idle_timer.sv
module hsl_idle_timer #(
  parameter int unsigned LIMIT = 130
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic all_high_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic             any_low;

  assign any_low = !all_high_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!arm_i || any_low) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT_C) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = arm_i && all_high_i && (cnt_q == LIMIT_C);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT_C);

  // R5
  low_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && any_low) |=> (cnt_q == '0));
endmodule

// File: rtl/hsl_stop_det.sv
module hsl_stop_det (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic sda_in_i,
  input  logic scl_in_i,
  input  logic sda_out_i,
  input  logic scl_out_i,
  output logic stop_o
);
  logic sda_prev_q;
  logic sda_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_prev_q <= 1'b1;
    else        sda_prev_q <= sda_in_i;
  end

  assign sda_rise = sda_in_i && !sda_prev_q;
  assign stop_o   = arm_i && sda_rise && scl_in_i && sda_out_i && scl_out_i;

  // R6
  stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> !$past(sda_in_i));
endmodule

// File: rtl/hsl_fsm.sv
module hsl_fsm
  import hsl_pkg::*;
#(
  parameter int unsigned INIT_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_s_i,
  input  logic       pg_s_i,
  input  logic       idle_done_i,
  input  logic       stop_i,
  output logic       armed_o,
  output logic       pre_q_o,
  output logic       link_q_o
);
  localparam int unsigned INIT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_CYCLES - 1);

  hsl_state_e        st_q, st_d;
  logic [INIT_W-1:0] init_cnt_q;
  logic              go;
  logic              init_end;

  assign go       = en_s_i && pg_s_i;
  assign init_end = (st_q == ST_INIT) && (init_cnt_q == INIT_LAST);

  always_comb begin
    st_d = st_q;
    if (!go) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF:    st_d = ST_INIT;
        ST_INIT:   if (init_end) st_d = ST_ARMED;
        ST_ARMED:  if (idle_done_i || stop_i) st_d = ST_LINKED;
        ST_LINKED: st_d = ST_LINKED;
        default:   st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_OFF;
      init_cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_INIT) init_cnt_q <= init_cnt_q + 1'b1;
      else                 init_cnt_q <= '0;
    end
  end

  assign armed_o  = (st_q == ST_ARMED);
  assign pre_q_o  = (st_q == ST_INIT) || (st_q == ST_ARMED);
  assign link_q_o = (st_q == ST_LINKED);

  // R1
  off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (st_q == ST_OFF));

  // R2
  link_from_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LINKED && $past(st_q) != ST_LINKED) |-> ($past(st_q) == ST_ARMED));

  // R2
  init_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED && $past(st_q) == ST_INIT) |-> ($past(init_cnt_q) == INIT_LAST));
endmodule

// File: rtl/hotswap_link_seq.sv
module hotswap_link_seq
  import hsl_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 200_000_000,
  parameter int unsigned IDLE_US     = 130,
  parameter int unsigned INIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic pwr_good_i,
  input  logic sda_in_i,
  input  logic scl_in_i,
  input  logic sda_out_i,
  input  logic scl_out_i,
  output logic connect_o,
  output logic precharge_o,
  output logic accel_o,
  output logic ready_o
);
  localparam int unsigned IDLE_LIMIT = idle_cycles(CLK_HZ, IDLE_US);
  localparam int unsigned NSYNC      = 6;

  // sync order: {pg, en, scl_out, sda_out, scl_in, sda_in}
  logic [NSYNC-1:0] raw, syn;
  logic en_s, pg_s, sda_in_s, scl_in_s, sda_out_s, scl_out_s;
  logic all_high, armed, idle_done, stop_seen, pre_q, link_q, gate;

  assign raw = {pwr_good_i, en_i, scl_out_i, sda_out_i, scl_in_i, sda_in_i};

  hsl_sync #(.W(NSYNC), .RST_VAL(6'b001111)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
  );

  assign {pg_s, en_s, scl_out_s, sda_out_s, scl_in_s, sda_in_s} = syn;
  assign all_high = sda_in_s && scl_in_s && sda_out_s && scl_out_s;

  hsl_idle_timer #(.LIMIT(IDLE_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm_i(armed), .all_high_i(all_high),
    .done_o(idle_done)
  );

  hsl_stop_det u_stop (
    .clk(clk), .rst_n(rst_n), .arm_i(armed),
    .sda_in_i(sda_in_s), .scl_in_i(scl_in_s),
    .sda_out_i(sda_out_s), .scl_out_i(scl_out_s),
    .stop_o(stop_seen)
  );

  hsl_fsm #(.INIT_CYCLES(INIT_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en_s_i(en_s), .pg_s_i(pg_s),
    .idle_done_i(idle_done), .stop_i(stop_seen),
    .armed_o(armed), .pre_q_o(pre_q), .link_q_o(link_q)
  );

  // Raw enable and power-good gate every output so removal acts at once.
  assign gate        = en_i && pwr_good_i;
  assign connect_o   = gate && link_q;
  assign accel_o     = gate && link_q;
  assign ready_o     = gate && link_q;
  assign precharge_o = gate && pre_q;

  // R3
  precharge_vs_connect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(precharge_o && connect_o));

  // R11
  accel_only_linked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accel_o |-> connect_o);

  // R8
  ready_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (connect_o && en_i));
endmodule

// File: tb/test_hotswap_link_seq.sv
module test_hotswap_link_seq;
  localparam int unsigned INIT = 16;
  localparam int unsigned IDLE = 130;  // 1 MHz nominal x 130 us
  // enable edge -> connected: 2 sync + 1 + INIT + IDLE + 1
  localparam int unsigned T_LINK = 3 + INIT + IDLE + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en, pg, sdi, sci, sdo, sco;
  logic connect, precharge, accel, ready;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hotswap_link_seq #(.CLK_HZ(1_000_000), .IDLE_US(130), .INIT_CYCLES(INIT)) i_hotswap_link_seq (
    .clk(clk), .rst_n(rst_n), .en_i(en), .pwr_good_i(pg),
    .sda_in_i(sdi), .scl_in_i(sci), .sda_out_i(sdo), .scl_out_i(sco),
    .connect_o(connect), .precharge_o(precharge), .accel_o(accel), .ready_o(ready)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string req, input logic c, input logic p);
    chk({req, " connect"}, connect, c);
    chk({req, " precharge"}, precharge, p);
    chk({req, " accel"}, accel, c);
    chk({req, " ready"}, ready, c);
  endtask

  task automatic park();
    en = 1'b0; pg = 1'b1;
    sdi = 1'b1; sci = 1'b1; sdo = 1'b1; sco = 1'b1;
    step(5);
  endtask

  // R4 R3 R8 R11: quiet bus connects on the idle timer
  task automatic t_idle();
    park();
    en = 1'b1;
    step(10);
    chk_all("R3 init", 1'b0, 1'b1);
    step(T_LINK - 6 - 10);
    chk_all("R4 before idle time", 1'b0, 1'b1);
    step(12);
    chk_all("R4 after idle time", 1'b1, 1'b0);
  endtask

  // R9 R10: drop enable, then re-enable requalifies
  task automatic t_disable();
    en = 1'b0;
    #1;
    chk_all("R9 immediate disable", 1'b0, 1'b0);
    step(5);
    en = 1'b1;
    step(10);
    chk_all("R10 reinit", 1'b0, 1'b1);
    step(T_LINK - 16);
    chk("R10 no early reconnect", connect, 1'b0);
    step(12);
    chk("R10 reconnect", connect, 1'b1);
  endtask

  // R1: power-good low blocks everything
  task automatic t_power();
    pg = 1'b0;
    #1;
    chk_all("R1 power lost", 1'b0, 1'b0);
    step(T_LINK + 20);
    chk_all("R1 held off", 1'b0, 1'b0);
    pg = 1'b1;
  endtask

  // R6: STOP after arming connects early
  task automatic t_stop();
    park();
    sdi = 1'b0;
    en = 1'b1;
    step(40);
    chk("R6 busy bus", connect, 1'b0);
    sdi = 1'b1;
    step(6);
    chk("R6 stop connects", connect, 1'b1);
    chk("R3 precharge off at link", precharge, 1'b0);
  endtask

  // R2: STOP during init is ignored; timer still works
  task automatic t_stop_in_init();
    park();
    sdi = 1'b0;
    en = 1'b1;
    step(5);
    sdi = 1'b1;
    step(35);
    chk("R2 init stop ignored", connect, 1'b0);
    step(T_LINK + 6 - 40);
    chk("R2 idle after init", connect, 1'b1);
  endtask

  // R7: rising edge with output side low does not connect
  task automatic t_stop_out_low();
    park();
    sdi = 1'b0; sdo = 1'b0;
    en = 1'b1;
    step(40);
    sdi = 1'b1;
    step(6);
    chk("R7 no connect with sdo low", connect, 1'b0);
    step(4);
    sdo = 1'b1;
    step(IDLE + 15);
    chk("R7 later idle connect", connect, 1'b1);
  endtask

  // R5: glitch on backplane clock restarts timer
  task automatic t_restart();
    park();
    en = 1'b1;
    step(100);
    sco = 1'b0;
    step(2);
    sco = 1'b1;
    step(T_LINK + 6 - 102);
    chk("R5 timer restarted", connect, 1'b0);
    step(100 + IDLE + 15 - T_LINK - 6);
    chk("R5 connect after restart", connect, 1'b1);
  endtask

  initial begin
    en = 1'b0; pg = 1'b1;
    sdi = 1'b1; sci = 1'b1; sdo = 1'b1; sco = 1'b1;
    step(3);
    chk_all("R1 reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    step(3);
    chk_all("R1 enable low", 1'b0, 1'b0);
    t_idle();
    t_disable();
    t_power();
    t_stop();
    t_stop_in_init();
    t_stop_out_low();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule